// File: doc/BRIEF.md
# Sideways Slot Access Policy Router

This block decides how a CPU access into the 16KB paged window at 0x8000-0xBFFF is serviced. A 4-bit paging register picks one of sixteen 16KB slots (256KB in all). Each slot has a fixed service policy, set by what is assumed to be fitted in it, rather than one cache policy for the whole window.

Slots 4 to 7 hold paged RAM. They are mapped permanently onto a 64KB internal RAM, and both reads and writes go there. Slots 9 to 15 hold stock ROM: reads take the cached-ROM path and writes are dropped. Slots 0 to 3 are plug-in cartridge sockets, so every access goes uncached to the external bus. Slot 8 follows a configuration input and is handled either as a cartridge socket or as ROM. A dropped write still completes in one cycle with its own one-cycle indication, and it makes no bus activity. Accesses outside the window, or in 0x8000-0x8FFF while the 4KB overlay owns that range, select nothing. The router registers its decision and presents it one clock after the strobe.

Top module: `swslot_router`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, svc_sel is 000, ram_addr is 0, and ram_wr and wr_discard are 0.
- R2: Every output reflects the inputs sampled on the clock edge where acc_stb is high, and is visible after that edge. A cycle without acc_stb gives svc_sel 000, ram_addr 0, ram_wr 0 and wr_discard 0 on the next cycle.
- R3: An access in the window to slots 4 to 7 gives svc_sel 001 (bit 0, internal RAM), ram_addr = {slot[1:0], cpu_addr[13:0]}, and ram_wr equal to is_write.
- R4: A read in the window to slots 9 to 15 gives svc_sel 010 (bit 1, ROM cache path).
- R5: A write in the window to slots 9 to 15 gives svc_sel 000 and wr_discard 1 for one cycle.
- R6: Any access in the window to slots 0 to 3 gives svc_sel 100 (bit 2, external uncached).
- R7: Slot 8 acts as slots 0 to 3 when slot8_rom is 0, and as slots 9 to 15 (read to the ROM path, write dropped) when slot8_rom is 1.
- R8: An access with cpu_addr below 0x8000 or at 0xC000 and above gives svc_sel 000 and wr_discard 0.
- R9: With ovl_en high, an access to 0x8000-0x8FFF gives svc_sel 000 and wr_discard 0. An access to 0x9000-0xBFFF is routed as if ovl_en were low.
- R10: At most one of svc_sel[2:0] and wr_discard is high. ram_wr is high only with svc_sel 001, and ram_addr is 0 whenever svc_sel is not 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Access strobe, one cycle per CPU access |
| is_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| slot | input | 4 | Current paged slot number |
| slot8_rom | input | 1 | 1 = slot 8 handled as ROM, 0 = as cartridge |
| ovl_en | input | 1 | 4KB overlay owns 0x8000-0x8FFF |
| svc_sel | output | 3 | One-hot service: bit0 internal RAM, bit1 ROM cache, bit2 external |
| ram_addr | output | 16 | Internal RAM index for slots 4-7 |
| ram_wr | output | 1 | Write to internal RAM |
| wr_discard | output | 1 | Write dropped and completed this cycle |

## Verification
A wrong slot classification shows in svc_sel, or as a wr_discard pulse, one cycle after the offending strobe. A fault in window or overlay decoding shows the same way, at the 0x8FFF/0x9000, 0x7FFF/0x8000 and 0xBFFF/0xC000 edges. Each slot is driven with both access directions, both slot-8 settings and both overlay settings, so a bad index mapping appears at once in ram_addr. A decision that outlives its strobe appears in the idle cycle that follows.

// File: rtl/swslot_pkg.sv
package swslot_pkg;

    typedef enum logic [1:0] {
        CLS_EXT = 2'd0,
        CLS_RAM = 2'd1,
        CLS_ROM = 2'd2,
        CLS_CFG = 2'd3
    } slot_cls_e;

    localparam int SEL_W   = 3;
    localparam int SEL_RAM = 0;
    localparam int SEL_ROM = 1;
    localparam int SEL_EXT = 2;

endpackage

// File: rtl/swslot_class_map.sv
module swslot_class_map
    import swslot_pkg::*;
#(
    parameter int SLOT_W    = 4,
    parameter int RAM_FIRST = 4,
    parameter int RAM_COUNT = 4,
    parameter int CFG_SLOT  = 8,
    parameter int ROM_FIRST = 9,
    localparam int N_SLOTS   = 1 << SLOT_W,
    localparam int RAM_IDX_W = $clog2(RAM_COUNT)
) (
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 cfg_rom,
    output slot_cls_e            cls,
    output logic [RAM_IDX_W-1:0] ram_idx
);

    slot_cls_e cls_tab [N_SLOTS];

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_tab
        if (i >= RAM_FIRST && i < RAM_FIRST + RAM_COUNT) begin : g_ram
            assign cls_tab[i] = CLS_RAM;
        end else if (i == CFG_SLOT) begin : g_cfg
            assign cls_tab[i] = CLS_CFG;
        end else if (i >= ROM_FIRST) begin : g_rom
            assign cls_tab[i] = CLS_ROM;
        end else begin : g_ext
            assign cls_tab[i] = CLS_EXT;
        end
    end

    logic [SLOT_W-1:0] rel_slot;

    always_comb begin
        cls = cls_tab[slot];
        if (cls == CLS_CFG) begin
            cls = cfg_rom ? CLS_ROM : CLS_EXT;
        end
        rel_slot = slot - SLOT_W'(RAM_FIRST);
        ram_idx  = rel_slot[RAM_IDX_W-1:0];
    end

endmodule

// File: rtl/swslot_window_dec.sv
module swslot_window_dec #(
    parameter int ADDR_W  = 16,
    parameter int OFS_W   = 14,
    parameter int WIN_TAG = 2,
    parameter int OVL_W   = 12,
    localparam int TAG_W  = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              ovl_en,
    output logic              hit,
    output logic [OFS_W-1:0]  offset
);

    logic in_win;
    logic ovl_hit;

    always_comb begin
        in_win  = (cpu_addr[ADDR_W-1:OFS_W] == TAG_W'(WIN_TAG));
        ovl_hit = ovl_en && (cpu_addr[OFS_W-1:OVL_W] == '0);
        hit     = in_win && !ovl_hit;
        offset  = cpu_addr[OFS_W-1:0];
    end

endmodule

// File: rtl/swslot_router.sv
module swslot_router
    import swslot_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFS_W     = 14,
    parameter int SLOT_W    = 4,
    parameter int RAM_FIRST = 4,
    parameter int RAM_COUNT = 4,
    parameter int CFG_SLOT  = 8,
    parameter int ROM_FIRST = 9,
    parameter int WIN_TAG   = 2,
    parameter int OVL_W     = 12,
    localparam int RAM_IDX_W = $clog2(RAM_COUNT),
    localparam int RAM_AW    = RAM_IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [SLOT_W-1:0] slot,
    input  logic              slot8_rom,
    input  logic              ovl_en,
    output logic [SEL_W-1:0]  svc_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_wr,
    output logic              wr_discard
);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [RAM_AW-1:0] addr;
        logic              wr;
        logic              discard;
    } route_t;

    slot_cls_e            cls;
    logic [RAM_IDX_W-1:0] ram_idx;
    logic                 win_hit;
    logic [OFS_W-1:0]     offset;
    route_t               route_d, route_q;

    swslot_class_map #(
        .SLOT_W   (SLOT_W),
        .RAM_FIRST(RAM_FIRST),
        .RAM_COUNT(RAM_COUNT),
        .CFG_SLOT (CFG_SLOT),
        .ROM_FIRST(ROM_FIRST)
    ) u_class_map (
        .slot   (slot),
        .cfg_rom(slot8_rom),
        .cls    (cls),
        .ram_idx(ram_idx)
    );

    swslot_window_dec #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .WIN_TAG(WIN_TAG),
        .OVL_W  (OVL_W)
    ) u_window_dec (
        .cpu_addr(cpu_addr),
        .ovl_en  (ovl_en),
        .hit     (win_hit),
        .offset  (offset)
    );

    always_comb begin
        route_d = '0;
        if (acc_stb && win_hit) begin
            unique case (cls)
                CLS_RAM: begin
                    route_d.sel[SEL_RAM] = 1'b1;
                    route_d.addr         = {ram_idx, offset};
                    route_d.wr           = is_write;
                end
                CLS_ROM: begin
                    if (is_write) begin
                        route_d.discard = 1'b1;
                    end else begin
                        route_d.sel[SEL_ROM] = 1'b1;
                    end
                end
                default: begin
                    route_d.sel[SEL_EXT] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    assign svc_sel    = route_q.sel;
    assign ram_addr   = route_q.addr;
    assign ram_wr     = route_q.wr;
    assign wr_discard = route_q.discard;

endmodule

// File: rtl/swslot_router_chk.sv
module swslot_router_chk #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 14,
    parameter int SLOT_W = 4,
    parameter int RAM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_stb,
    input logic              is_write,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [SLOT_W-1:0] slot,
    input logic [2:0]        svc_sel,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              ram_wr,
    input logic              wr_discard
);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({svc_sel, wr_discard}));

    assert_ramwr_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> svc_sel == 3'b001);

    assert_addr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_sel != 3'b001) |-> ram_addr == '0);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_stb) |-> (svc_sel == '0 && !wr_discard && !ram_wr));

    assert_ram_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        svc_sel[0] |-> (ram_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0])
                        && ram_wr == $past(is_write)));

    assert_discard_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_discard |-> ($past(is_write) && $past(slot) >= SLOT_W'(8)));

    assert_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_stb) && $past(cpu_addr[ADDR_W-1:OFS_W]) != 2'b10)
        |-> (svc_sel == '0 && !wr_discard));

endmodule

bind swslot_router swslot_router_chk #(
    .ADDR_W(ADDR_W),
    .OFS_W (OFS_W),
    .SLOT_W(SLOT_W),
    .RAM_AW(RAM_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_stb   (acc_stb),
    .is_write  (is_write),
    .cpu_addr  (cpu_addr),
    .slot      (slot),
    .svc_sel   (svc_sel),
    .ram_addr  (ram_addr),
    .ram_wr    (ram_wr),
    .wr_discard(wr_discard)
);

// File: tb/swslot_router_bench.sv
module swslot_router_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_stb = 1'b0;
    logic        is_write = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [3:0]  slot = '0;
    logic        slot8_rom = 1'b0;
    logic        ovl_en = 1'b0;
    logic [2:0]  svc_sel;
    logic [15:0] ram_addr;
    logic        ram_wr;
    logic        wr_discard;

    int checks = 0;
    int errors = 0;

    logic [2:0]  exp_sel = '0;
    logic [15:0] exp_addr = '0;
    logic        exp_wr = 1'b0;
    logic        exp_disc = 1'b0;
    string       exp_req = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    swslot_router u_swslot_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_stb   (acc_stb),
        .is_write  (is_write),
        .cpu_addr  (cpu_addr),
        .slot      (slot),
        .slot8_rom (slot8_rom),
        .ovl_en    (ovl_en),
        .svc_sel   (svc_sel),
        .ram_addr  (ram_addr),
        .ram_wr    (ram_wr),
        .wr_discard(wr_discard)
    );

    task automatic compare();
        checks++;
        if (svc_sel !== exp_sel || ram_addr !== exp_addr ||
            ram_wr !== exp_wr || wr_discard !== exp_disc) begin
            errors++;
            $display("FAIL %s: sel=%b addr=%h wr=%b disc=%b expected sel=%b addr=%h wr=%b disc=%b",
                     exp_req, svc_sel, ram_addr, ram_wr, wr_discard,
                     exp_sel, exp_addr, exp_wr, exp_disc);
        end
    endtask

    task automatic model(input bit stb, input bit w, input int a, input int s,
                         input bit cfg, input bit ovl);
        exp_sel = '0; exp_addr = '0; exp_wr = 1'b0; exp_disc = 1'b0;
        if (!stb) begin
            exp_req = "R2";
        end else if (a < 'h8000 || a >= 'hC000) begin
            exp_req = "R8";
        end else if (ovl && a < 'h9000) begin
            exp_req = "R9";
        end else if (s >= 4 && s <= 7) begin
            exp_req  = "R3";
            exp_sel  = 3'b001;
            exp_addr = 16'((s - 4) * 'h4000 + (a - 'h8000));
            exp_wr   = w;
        end else if (s <= 3) begin
            exp_req = "R6";
            exp_sel = 3'b100;
        end else if (s == 8 && !cfg) begin
            exp_req = "R7";
            exp_sel = 3'b100;
        end else begin
            exp_req = (s == 8) ? "R7" : (w ? "R5" : "R4");
            if (w) exp_disc = 1'b1;
            else   exp_sel  = 3'b010;
        end
    endtask

    task automatic step(input bit stb, input bit w, input int a, input int s,
                        input bit cfg, input bit ovl);
        @(negedge clk);
        compare();
        acc_stb = stb; is_write = w; cpu_addr = 16'(a);
        slot = 4'(s); slot8_rom = cfg; ovl_en = ovl;
        model(stb, w, a, s, cfg, ovl);
    endtask

    initial begin
        int addrs[8] = '{'h8000, 'h8FFF, 'h9000, 'hA5A5, 'hBFFF, 'h7FFF, 'hC000, 'h3000};
        // R1: reset holds outputs low, even with a strobe presented
        exp_req = "R1";
        acc_stb = 1'b1; cpu_addr = 16'h9000; slot = 4'd5; is_write = 1'b1;
        repeat (3) begin
            @(negedge clk);
            compare();
        end
        acc_stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare();
        model(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int cfg = 0; cfg < 2; cfg++) begin
                    for (int ovl = 0; ovl < 2; ovl++) begin
                        for (int ai = 0; ai < 8; ai++) begin
                            step(1'b1, w[0], addrs[ai], s, cfg[0], ovl[0]);
                            if (ai == 3) step(1'b0, 1'b1, 'h9123, 6, 1'b0, 1'b0);
                        end
                    end
                end
            end
        end
        // back-to-back accesses to different slots (R3, R6, R5)
        step(1'b1, 1'b1, 'hBFFF, 7, 1'b0, 1'b0);
        step(1'b1, 1'b0, 'h8001, 2, 1'b0, 1'b0);
        step(1'b1, 1'b1, 'hA000, 15, 1'b0, 1'b0);
        step(1'b1, 1'b0, 'h8000, 4, 1'b0, 1'b1);
        step(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule